// File: doc/BRIEF.md
# Flash Page Buffer Load Sequencer

The block takes one page of program data after a page-program command has been accepted and before the internal programming engine starts. The command interpreter sends a one-cycle start pulse. The block then takes a fixed-length stream of synchronous writes, each with an address and a data value, and places each one in an internal page register array. It checks two things on every write: the low address bits must step up by exactly one, and the page address must stay the same. When the last location arrives, the block reports load complete together with the page base address. The programming engine can then read any buffered word through a separate read port.

The page size depends on the mode sampled with the start pulse. In word mode a page is 128 sixteen-bit words, indexed by the low seven word-address bits. In byte mode a page is 256 bytes, indexed by the low seven word-address bits with the byte-lane bit appended as the least significant bit. Each pair of bytes is packed into one stored word. A write that breaks the order, or that names a different page, ends the load with an error flag and does not signal completion.

Top module: `flash_page_loader`

## Requirements
- R1: After synchronous reset, and after reset is applied in the middle of a load, `busy_o`, `done_o` and `seq_err_o` are all 0.
- R2: While no load is in progress, writes are ignored. They raise neither `done_o` nor `seq_err_o` and leave the stored page unchanged.
- R3: In word mode (`byte_mode_i`=0 at start), the block expects 128 writes. Write n (0..127) must carry `wr_addr_i[6:0]`=n, and its full 16-bit `wr_data_i` is stored at word n.
- R4: In byte mode (`byte_mode_i`=1 at start), the block expects 256 writes. Write n (0..255) must carry {`wr_addr_i[6:0]`,`wr_lsb_i`}=n. Its byte `wr_data_i[7:0]` goes to word n>>1: the low byte when `wr_lsb_i`=0 and the high byte when `wr_lsb_i`=1.
- R5: The page address `wr_addr_i[18:7]` of the first write of a load is latched. `page_base_o` then equals that page address with bits [6:0] zero.
- R6: `done_o` is a single-cycle pulse in the cycle after the last write of the page is accepted, and `busy_o` falls in that same cycle.
- R7: During a load, a write whose sequence index differs from the number of writes already accepted sets `seq_err_o` in the next cycle, ends the load and gives no `done_o`.
- R8: During a load, a write after the first whose page address differs from the latched page sets `seq_err_o` and ends the load without `done_o`.
- R9: `abort_i` ends any load in the next cycle with no `done_o` and no change to `seq_err_o`. The next load starts again from index 0.
- R10: `seq_err_o` holds its value until the next start pulse, which clears it.
- R11: A start pulse during a load restarts the expected sequence at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort_i | input | 1 | Cancel the current load |
| start_i | input | 1 | Page-program accepted, begin a load |
| byte_mode_i | input | 1 | 1 = byte mode, 0 = word mode (sampled with start) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 19 | Word address of the write |
| wr_lsb_i | input | 1 | Byte-lane address bit (byte mode) |
| wr_data_i | input | 16 | Write data (byte mode uses bits 7:0) |
| rd_idx_i | input | 7 | Word index for buffer read |
| rd_data_o | output | 16 | Buffered word at `rd_idx_i` |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load complete pulse |
| seq_err_o | output | 1 | Sequence or page error flag |
| page_base_o | output | 19 | Base word address of the loaded page |

## Verification
The bench exercises the final index in both modes. A pointer compared against the wrong limit would pulse `done_o` one write early or late, or never. Byte packing is checked by reading every word back, which catches swapped lanes or a wrong shift of the byte index. Skipped indices, page changes, aborts, restarts and reset in mid-load are each driven on their own. A design that mishandled one of these would miss the error flag, finish a load it should have dropped, or reject a correct reload because its pointer was not cleared.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_LOAD} ld_state_t;

  // sequence index carried by one write
  function automatic logic [7:0] seq_index(input logic byte_mode,
                                           input logic [6:0] low_addr,
                                           input logic lsb);
    return byte_mode ? {low_addr, lsb} : {1'b0, low_addr};
  endfunction

  // highest index of a page in the given mode
  function automatic logic [7:0] last_index(input logic byte_mode);
    return byte_mode ? 8'd255 : 8'd127;
  endfunction

  // byte lanes touched by the write at sequence index idx
  function automatic logic [1:0] lane_mask(input logic byte_mode, input logic [7:0] idx);
    if (!byte_mode) return 2'b11;
    return idx[0] ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/fpl_seq_ctrl.sv
module fpl_seq_ctrl
  import fpl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int PAGE_LOG2 = 7,
  localparam int PG_W = ADDR_W - PAGE_LOG2,
  localparam int PTR_W = PAGE_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              byte_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_lsb_i,
  output logic              acc_o,
  output logic              err_o,
  output logic              last_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              seq_err_o,
  output logic [PG_W-1:0]   page_o
);
  ld_state_t        state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             mode_q, done_q, err_q;
  logic [PG_W-1:0]  page_q;
  logic [PG_W-1:0]  page_in;
  logic [PTR_W-1:0] idx_in;
  logic             hit, idx_ok, page_ok;

  assign page_in = wr_addr_i[ADDR_W-1:PAGE_LOG2];
  assign idx_in  = seq_index(mode_q, wr_addr_i[PAGE_LOG2-1:0], wr_lsb_i);
  assign hit     = (state_q == ST_LOAD) && wr_en_i && !start_i && !abort_i;
  assign idx_ok  = (idx_in == ptr_q);
  assign page_ok = (ptr_q == '0) || (page_in == page_q);
  assign acc_o   = hit && idx_ok && page_ok;
  assign err_o   = hit && !(idx_ok && page_ok);
  assign last_o  = acc_o && (ptr_q == last_index(mode_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      page_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        ptr_q   <= '0;
      end else if (start_i) begin
        state_q <= ST_LOAD;
        ptr_q   <= '0;
        err_q   <= 1'b0;
        mode_q  <= byte_mode_i;
      end else if (acc_o) begin
        if (ptr_q == '0) page_q <= page_in;
        if (last_o) begin
          state_q <= ST_IDLE;
          ptr_q   <= '0;
          done_q  <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (err_o) begin
        state_q <= ST_IDLE;
        ptr_q   <= '0;
        err_q   <= 1'b1;
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign mode_o    = mode_q;
  assign busy_o    = (state_q == ST_LOAD);
  assign done_o    = done_q;
  assign seq_err_o = err_q;
  assign page_o    = page_q;
endmodule

// File: rtl/fpl_page_store.sv
module fpl_page_store
  import fpl_pkg::*;
#(
  parameter int PAGE_LOG2 = 7,
  parameter int DATA_W = 16,
  localparam int WORDS = 1 << PAGE_LOG2,
  localparam int PTR_W = PAGE_LOG2 + 1,
  localparam int HALF = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 wr_stb_i,
  input  logic                 mode_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [PAGE_LOG2-1:0] rd_idx_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0]    mem [WORDS];
  logic [PAGE_LOG2-1:0] widx;
  logic [1:0]           lanes;
  logic [DATA_W-1:0]    wdata;

  assign widx  = mode_i ? ptr_i[PTR_W-1:1] : ptr_i[PAGE_LOG2-1:0];
  assign lanes = lane_mask(mode_i, ptr_i);
  assign wdata = mode_i ? {data_i[HALF-1:0], data_i[HALF-1:0]} : data_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_stb_i && lanes[g]) mem[widx][g*HALF +: HALF] <= wdata[g*HALF +: HALF];
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader
  import fpl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int PAGE_LOG2 = 7,
  parameter int DATA_W = 16,
  localparam int PG_W = ADDR_W - PAGE_LOG2,
  localparam int PTR_W = PAGE_LOG2 + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort_i,
  input  logic                 start_i,
  input  logic                 byte_mode_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic                 wr_lsb_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [PAGE_LOG2-1:0] rd_idx_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 seq_err_o,
  output logic [ADDR_W-1:0]    page_base_o
);
  // named internal events, observed by the checker
  logic             ev_accept, ev_error, ev_last, cur_mode;
  logic [PTR_W-1:0] cur_ptr;
  logic [PG_W-1:0]  cur_page;

  fpl_seq_ctrl #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .abort_i(abort_i), .start_i(start_i),
    .byte_mode_i(byte_mode_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_lsb_i(wr_lsb_i), .acc_o(ev_accept), .err_o(ev_error), .last_o(ev_last),
    .ptr_o(cur_ptr), .mode_o(cur_mode), .busy_o(busy_o), .done_o(done_o),
    .seq_err_o(seq_err_o), .page_o(cur_page)
  );

  fpl_page_store #(.PAGE_LOG2(PAGE_LOG2), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_stb_i(ev_accept), .mode_i(cur_mode), .ptr_i(cur_ptr),
    .data_i(wr_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  assign page_base_o = {cur_page, {PAGE_LOG2{1'b0}}};
endmodule

// File: rtl/flash_page_loader_chk.sv
module flash_page_loader_chk (
  input logic clk,
  input logic rst,
  input logic abort_i,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic seq_err_o,
  input logic ev_error,
  input logic ev_last
);
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    ev_last |=> (done_o && !busy_o));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_error_flag_r7: assert property (@(posedge clk) disable iff (rst)
    ev_error |=> (seq_err_o && !done_o && !busy_o));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_o && !done_o));

  p_abort_keeps_err_r9: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> $stable(seq_err_o));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i) |=> (busy_o && !seq_err_o));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> (!done_o && $stable(seq_err_o)));

  p_done_clean_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !seq_err_o);
endmodule

bind flash_page_loader flash_page_loader_chk u_chk (
  .clk(clk), .rst(rst), .abort_i(abort_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .seq_err_o(seq_err_o),
  .ev_error(ev_error), .ev_last(ev_last)
);

// File: tb/sim_flash_page_loader.sv
`timescale 1ns/1ps
module sim_flash_page_loader;
  logic        clk = 1'b0;
  logic        rst, abort_i, start_i, byte_mode_i, wr_en_i, wr_lsb_i;
  logic [18:0] wr_addr_i;
  logic [15:0] wr_data_i;
  logic [6:0]  rd_idx_i;
  logic [15:0] rd_data_o;
  logic        busy_o, done_o, seq_err_o;
  logic [18:0] page_base_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_page_loader u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wpat(input int i, input int salt);
    return {8'(i ^ salt), 8'(~i)};
  endfunction
  function automatic logic [7:0] bpat(input int b, input int salt);
    return 8'(b * 3 + salt);
  endfunction

  task automatic pulse_start(input logic bm);
    @(negedge clk); start_i = 1; byte_mode_i = bm; wr_en_i = 0;
    @(negedge clk); start_i = 0;
  endtask

  task automatic put(input logic [11:0] pg, input logic [7:0] idx7_lsb, input logic bm, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_data_i = d;
    if (bm) begin wr_addr_i = {pg, idx7_lsb[7:1]}; wr_lsb_i = idx7_lsb[0]; end
    else begin wr_addr_i = {pg, idx7_lsb[6:0]}; wr_lsb_i = 0; end
  endtask

  task automatic stop_wr();
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic readback_word(input int salt, input string req);
    for (int i = 0; i < 128; i++) begin
      rd_idx_i = 7'(i); #0.5;
      chk(rd_data_o == wpat(i, salt), req, rd_data_o, wpat(i, salt));
    end
  endtask

  task automatic load_word(input logic [11:0] pg, input int salt);
    pulse_start(0);
    for (int i = 0; i < 128; i++) put(pg, 8'(i), 0, wpat(i, salt));
    stop_wr();
    chk(done_o === 1'b1, "R6 done after last word", done_o, 1);
    chk(busy_o === 1'b0, "R6 busy low with done", busy_o, 0);
    chk(page_base_o == {pg, 7'h0}, "R5 page base", page_base_o, {pg, 7'h0});
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done single pulse", done_o, 0);
  endtask

  task automatic t_reset();
    rst = 1; abort_i = 0; start_i = 0; byte_mode_i = 0; wr_en_i = 0;
    wr_lsb_i = 0; wr_addr_i = '0; wr_data_i = '0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!busy_o && !done_o && !seq_err_o, "R1 reset state", {busy_o, done_o, seq_err_o}, 0);
  endtask

  task automatic t_word();
    load_word(12'h5A3, 8'h21);
    readback_word(8'h21, "R3 word data");
  endtask

  task automatic t_idle_ignored();
    put(12'h5A3, 0, 0, 16'hFFFF);
    stop_wr();
    chk(!done_o && !seq_err_o && !busy_o, "R2 idle write no effect", {busy_o, done_o, seq_err_o}, 0);
    @(negedge clk);
    rd_idx_i = 0; #0.5;
    chk(rd_data_o == wpat(0, 8'h21), "R2 buffer unchanged", rd_data_o, wpat(0, 8'h21));
  endtask

  task automatic t_byte();
    logic [15:0] e;
    pulse_start(1);
    for (int b = 0; b < 256; b++) put(12'h0C7, 8'(b), 1, {8'hEE, bpat(b, 5)});
    stop_wr();
    chk(done_o === 1'b1, "R6 done after last byte", done_o, 1);
    chk(page_base_o == {12'h0C7, 7'h0}, "R5 page base byte mode", page_base_o, {12'h0C7, 7'h0});
    for (int w = 0; w < 128; w++) begin
      rd_idx_i = 7'(w); #0.5;
      e = {bpat(2*w+1, 5), bpat(2*w, 5)};
      chk(rd_data_o == e, "R4 byte packing", rd_data_o, e);
    end
  endtask

  task automatic t_order_err();
    pulse_start(0);
    put(12'h100, 0, 0, 16'h1); put(12'h100, 1, 0, 16'h2); put(12'h100, 3, 0, 16'h3);
    stop_wr();
    chk(seq_err_o === 1'b1, "R7 skipped index flags error", seq_err_o, 1);
    chk(!busy_o && !done_o, "R7 load ended no done", {busy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    chk(seq_err_o === 1'b1, "R10 error held", seq_err_o, 1);
    pulse_start(0);
    chk(seq_err_o === 1'b0 && busy_o, "R10 start clears error", {busy_o, seq_err_o}, 2);
  endtask

  task automatic t_page_err();
    pulse_start(0);
    put(12'h200, 0, 0, 16'h1); put(12'h201, 1, 0, 16'h2);
    stop_wr();
    chk(seq_err_o === 1'b1, "R8 page change flags error", seq_err_o, 1);
    chk(!busy_o && !done_o, "R8 load ended no done", {busy_o, done_o}, 0);
  endtask

  task automatic t_abort();
    pulse_start(0);
    for (int i = 0; i < 5; i++) put(12'h300, 8'(i), 0, 16'h0);
    @(negedge clk); wr_en_i = 0; abort_i = 1;
    @(negedge clk); abort_i = 0;
    chk(!busy_o && !done_o && !seq_err_o, "R9 abort idle", {busy_o, done_o, seq_err_o}, 0);
    load_word(12'h301, 8'h44);
    readback_word(8'h44, "R9 reload from index 0");
  endtask

  task automatic t_restart();
    pulse_start(0);
    for (int i = 0; i < 10; i++) put(12'h400, 8'(i), 0, 16'h0);
    stop_wr();
    load_word(12'h402, 8'h6B);
    chk(!seq_err_o, "R11 restart no error", seq_err_o, 0);
    readback_word(8'h6B, "R11 restart data");
  endtask

  task automatic t_midreset();
    pulse_start(1);
    for (int i = 0; i < 4; i++) put(12'h500, 8'(i), 1, 16'h0);
    @(negedge clk); wr_en_i = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk(!busy_o && !done_o && !seq_err_o, "R1 reset mid-load", {busy_o, done_o, seq_err_o}, 0);
  endtask

  initial begin
    t_reset();
    t_word();
    t_idle_ignored();
    t_byte();
    t_order_err();
    t_page_err();
    t_abort();
    t_restart();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule